// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block converts parallel bytes into asynchronous serial frames on one output line. A frame starts with a single low start bit. The active data bits follow, least significant bit first. An optional parity bit comes next, then the stop period, and after that the line returns to its high idle level. An 8-bit control word sets the frame format at run time:

- data length of 5 to 8 bits;
- parity: none, odd, even, or stuck at a fixed value;
- stop period: one bit, one and a half bits, or two bits.

The same control word holds a break control, which pulls the line low. It also holds a divisor-select bit. While that bit is set, bytes offered on the input handshake go to the baud divisor instead of starting frames.

Timing comes from a divisor counter. It produces one baud enable every `divisor` clocks, and a divisor of 0 counts as 1. Each bit period is 16 enables long, and a half stop bit is 8. The sequencer is an enumerated state machine with the states IDLE, START, DATA, PARITY and STOP. Its transitions are:

- IDLE→START when a byte is accepted.
- START→DATA after 16 enables.
- DATA→DATA after each data bit except the last.
- DATA→PARITY after the last data bit when parity is enabled.
- DATA→STOP after the last data bit when parity is disabled.
- PARITY→STOP after 16 enables.
- STOP→START when a new byte is accepted on the final enable of the stop period.
- STOP→IDLE when no byte is accepted on that final enable.

The data length, parity and stop settings are captured when a byte is accepted. A control write during a frame therefore affects only later frames.

Top module: `sertx_engine`

## Requirements
- R1: After reset the control word is 0, `txd` is 1, `busy` is 0 and `in_ready` is 1. With control 0 a frame has 5 data bits, no parity and one stop bit. While idle with no break, `txd` stays 1.
- R2: A byte accepted on a clock edge (`in_valid` and `in_ready` both 1, control bit 7 clear) makes `txd` 0 from the next cycle for 16 baud enables. Data bits follow least significant bit first, each lasting 16 enables. After the stop period the block returns to idle with `txd` 1.
- R3: Control bits [1:0] give the data length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits.
- R4: Control bit 3 = 1 adds one parity bit after the data bits, computed over the active data bits only. With bits [5:3] = 001 the parity is odd (total count of ones is odd). With 011 it is even.
- R5: With bits [5:3] = 101 the parity bit is always 1. With 111 it is always 0.
- R6: When control bit 2 is 0 the stop period is 16 enables. When bit 2 is 1 it is 24 enables for 5-bit data and 32 enables for 6, 7 or 8 bits. `txd` is 1 throughout the stop period.
- R7: While control bit 6 is 1, `txd` is 0 from the cycle after the write. `txd` returns to normal when the bit is cleared.
- R8: While control bit 7 is 1, `in_ready` is 1 and an accepted byte loads the baud divisor without starting a frame. A baud enable then occurs every `divisor` clocks, and a divisor of 0 behaves as 1.
- R9: When control bit 7 is 0, `in_ready` is 1 only while idle or on the final baud enable of the stop period. A byte accepted there starts its start bit with no idle gap.
- R10: A control-word write during a frame does not change that frame's length, parity or stop period. The new format applies from the next accepted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 8 | Control word value |
| in_valid | input | 1 | Input byte valid |
| in_data | input | DATA_W | Byte to send, or divisor value when control bit 7 is set |
| in_ready | output | 1 | Block can accept `in_data` this cycle |
| txd | output | 1 | Serial line output, idle high |
| busy | output | 1 | A frame is in progress |

## Verification
A byte accepted on edge N puts the start bit on `txd` in the cycle after N. Baud enable k of the frame is therefore due at cycle k×divisor after that edge. The bench samples `txd` at every falling clock edge from that cycle on and computes the expected level from the control word, the byte and the enable index. `busy` must fall and `in_ready` must be high in the cycle after the frame's last enable. `in_ready` must also rise in exactly the last cycle of the stop period and in no earlier cycle. A control write shows on `txd` (break) or in the divisor one cycle after its edge, so those checks sample at the next falling edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    // Frame format, laid out to match control word bits [5:0]
    typedef struct packed {
        logic       stick;      // bit 5: parity forced to ~even
        logic       even;       // bit 4: even parity select
        logic       par_en;     // bit 3: parity present
        logic       long_stop;  // bit 2: 1.5 or 2 stop periods
        logic [1:0] len;        // bits 1:0: data length minus 5
    } frame_fmt_t;

    localparam int CTL_W      = 8;
    localparam int CTL_BREAK  = 6;
    localparam int CTL_DIVSEL = 7;
    localparam int MIN_BITS   = 5;

    function automatic frame_fmt_t fmt_from_ctl(input logic [CTL_W-1:0] c);
        return frame_fmt_t'(c[5:0]);
    endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int               DIV_W     = 8,
    parameter logic [DIV_W-1:0] DIV_RESET = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             sync,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] reload;

    // A divisor of zero behaves as one
    assign reload = (div_q == '0) ? '0 : div_q - 1'b1;
    assign tick   = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_RESET;
        end else if (div_we) begin
            div_q <= div_wdata;
        end
    end

    // Restarted when a frame leaves idle so the first bit is full length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (sync || tick) begin
            cnt_q <= reload;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/sertx_fmt.sv
module sertx_fmt
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int SUB_W  = 5,
    parameter int IDX_W  = 4
) (
    input  frame_fmt_t        fmt,
    input  logic [DATA_W-1:0] data,
    output logic [IDX_W-1:0]  nbits,
    output logic              par_bit,
    output logic [SUB_W-1:0]  stop_last
);

    localparam logic [SUB_W-1:0] STOP_ONE  = SUB_W'(OSR - 1);
    localparam logic [SUB_W-1:0] STOP_HALF = SUB_W'(OSR + OSR/2 - 1);
    localparam logic [SUB_W-1:0] STOP_TWO  = SUB_W'(2*OSR - 1);

    logic [DATA_W-1:0] active;
    logic              ones_odd;

    assign nbits = IDX_W'(MIN_BITS) + IDX_W'(fmt.len);

    // Only bits inside the selected length count toward parity
    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign active[g] = data[g] & (IDX_W'(g) < nbits);
    end

    assign ones_odd = ^active;

    always_comb begin
        if (fmt.stick) begin
            par_bit = ~fmt.even;
        end else if (fmt.even) begin
            par_bit = ones_odd;
        end else begin
            par_bit = ~ones_odd;
        end
    end

    always_comb begin
        if (!fmt.long_stop) begin
            stop_last = STOP_ONE;
        end else if (fmt.len == 2'b00) begin
            stop_last = STOP_HALF;
        end else begin
            stop_last = STOP_TWO;
        end
    end

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int SUB_W  = 5,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] ld_data,
    input  frame_fmt_t        ld_fmt,
    input  logic [IDX_W-1:0]  ld_nbits,
    input  logic              ld_par,
    input  logic [SUB_W-1:0]  ld_stop_last,
    input  logic              brk,
    output logic              txd,
    output logic              busy,
    output logic              frame_done,
    output tx_state_e         state_o,
    output frame_fmt_t        fmt_o
);

    localparam logic [SUB_W-1:0] BIT_LAST = SUB_W'(OSR - 1);

    tx_state_e         state_q, state_d;
    logic [SUB_W-1:0]  sub_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sh_q;
    frame_fmt_t        fmt_q;
    logic [IDX_W-1:0]  nbits_q;
    logic              par_q;
    logic [SUB_W-1:0]  stop_last_q;

    logic bit_end;
    logic stop_end;
    logic last_data;
    logic line;

    assign bit_end    = tick && (sub_q == BIT_LAST);
    assign stop_end   = tick && (sub_q == stop_last_q);
    assign last_data  = (idx_q == nbits_q - 1'b1);
    assign frame_done = (state_q == ST_STOP) && stop_end;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA: begin
                if (bit_end && last_data) begin
                    state_d = fmt_q.par_en ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP: begin
                if (stop_end) begin
                    state_d = start ? ST_START : ST_IDLE;
                end
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Frame datapath: tick counter, bit index, shifter, captured format
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q       <= '0;
            idx_q       <= '0;
            sh_q        <= '0;
            fmt_q       <= '0;
            nbits_q     <= IDX_W'(MIN_BITS);
            par_q       <= 1'b0;
            stop_last_q <= BIT_LAST;
        end else if (start) begin
            sub_q       <= '0;
            idx_q       <= '0;
            sh_q        <= ld_data;
            fmt_q       <= ld_fmt;
            nbits_q     <= ld_nbits;
            par_q       <= ld_par;
            stop_last_q <= ld_stop_last;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sub_q <= '0;
                end
                ST_START, ST_PARITY: begin
                    if (tick) sub_q <= bit_end ? '0 : sub_q + 1'b1;
                end
                ST_DATA: begin
                    if (bit_end) begin
                        sub_q <= '0;
                        idx_q <= idx_q + 1'b1;
                        sh_q  <= sh_q >> 1;
                    end else if (tick) begin
                        sub_q <= sub_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (tick) sub_q <= stop_end ? '0 : sub_q + 1'b1;
                end
                default: begin
                    sub_q <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   line = 1'b1;
            ST_START:  line = 1'b0;
            ST_DATA:   line = sh_q[0];
            ST_PARITY: line = par_q;
            ST_STOP:   line = 1'b1;
            default:   line = 1'b1;
        endcase
        txd     = brk ? 1'b0 : line;
        busy    = (state_q != ST_IDLE);
        state_o = state_q;
        fmt_o   = fmt_q;
    end

endmodule

// File: rtl/sertx_engine.sv
module sertx_engine
    import sertx_pkg::*;
#(
    parameter int               DATA_W    = 8,
    parameter int               DIV_W     = 8,
    parameter int               OSR       = 16,
    parameter logic [DIV_W-1:0] DIV_RESET = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd,
    output logic              busy
);

    localparam int SUB_W = $clog2(2*OSR);
    localparam int IDX_W = $clog2(DATA_W + 1);

    logic [CTL_W-1:0] ctl_q;
    logic             div_mode;
    logic             brk;
    logic             accept;
    logic             tick;
    logic             sync;

    tx_state_e        fsm_state;
    logic             frame_done;
    frame_fmt_t       cur_fmt;

    frame_fmt_t       new_fmt;
    logic [IDX_W-1:0] new_nbits;
    logic             new_par;
    logic [SUB_W-1:0] new_stop_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= ctl_wdata;
        end
    end

    assign div_mode = ctl_q[CTL_DIVSEL];
    assign brk      = ctl_q[CTL_BREAK];
    assign new_fmt  = fmt_from_ctl(ctl_q);

    assign in_ready = div_mode || (fsm_state == ST_IDLE) || frame_done;
    assign accept   = in_valid && in_ready && !div_mode;
    assign sync     = accept && (fsm_state == ST_IDLE);

    sertx_baud #(
        .DIV_W     (DIV_W),
        .DIV_RESET (DIV_RESET)
    ) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_we    (in_valid && div_mode),
        .div_wdata (DIV_W'(in_data)),
        .sync      (sync),
        .tick      (tick)
    );

    sertx_fmt #(
        .DATA_W    (DATA_W),
        .OSR       (OSR),
        .SUB_W     (SUB_W),
        .IDX_W     (IDX_W)
    ) u_fmt (
        .fmt       (new_fmt),
        .data      (in_data),
        .nbits     (new_nbits),
        .par_bit   (new_par),
        .stop_last (new_stop_last)
    );

    sertx_fsm #(
        .DATA_W       (DATA_W),
        .OSR          (OSR),
        .SUB_W        (SUB_W),
        .IDX_W        (IDX_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .start        (accept),
        .ld_data      (in_data),
        .ld_fmt       (new_fmt),
        .ld_nbits     (new_nbits),
        .ld_par       (new_par),
        .ld_stop_last (new_stop_last),
        .brk          (brk),
        .txd          (txd),
        .busy         (busy),
        .frame_done   (frame_done),
        .state_o      (fsm_state),
        .fmt_o        (cur_fmt)
    );

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk
    import sertx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic [7:0] ctl_wdata,
    input logic       in_valid,
    input logic       in_ready,
    input logic       txd,
    input logic       busy,
    input logic [7:0] ctl_q,
    input tx_state_e  fsm_state,
    input logic       frame_done,
    input frame_fmt_t cur_fmt
);

    p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE && !ctl_q[6]) |-> txd);

    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !ctl_q[7]) |=> (busy && !txd && fsm_state == ST_START));

    p_stick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_PARITY && cur_fmt.stick && !ctl_q[6]) |-> (txd == !cur_fmt.even));

    p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_STOP && !ctl_q[6]) |-> txd);

    p_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[6]) |=> !txd);

    p_div_no_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctl_q[7] && !busy) |=> !busy);

    p_ready_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_ready && !ctl_q[7]) |-> (fsm_state == ST_STOP && frame_done));

    p_fmt_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(frame_done)) |-> $stable(cur_fmt));

endmodule

bind sertx_engine sertx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .txd        (txd),
    .busy       (busy),
    .ctl_q      (ctl_q),
    .fsm_state  (fsm_state),
    .frame_done (frame_done),
    .cur_fmt    (cur_fmt)
);

// File: tb/sim_sertx_engine.sv
module sim_sertx_engine;

    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       txd;
    logic       busy;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    sertx_engine u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .txd       (txd),
        .busy      (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [7:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic int frame_ticks(input logic [7:0] c);
        int n = nbits_of(c);
        int stop = c[2] ? ((n == 5) ? 24 : 32) : 16;
        return 16 * (1 + n + int'(c[3])) + stop;
    endfunction

    function automatic logic par_of(input logic [7:0] c, input logic [7:0] d);
        logic x = 1'b0;
        for (int b = 0; b < nbits_of(c); b++) x ^= d[b];
        if (c[5]) return ~c[4];
        return c[4] ? x : ~x;
    endfunction

    // Expected line level at baud enable k of a frame
    function automatic logic exp_line(input logic [7:0] c, input logic [7:0] d, input int k);
        int n = nbits_of(c);
        int r;
        if (k < 16) return 1'b0;
        r = k - 16;
        if (r < 16 * n) return d[r / 16];
        r -= 16 * n;
        if (c[3] && r < 16) return par_of(c, d);
        return 1'b1;
    endfunction

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    // Returns at the falling edge of the first cycle after acceptance
    task automatic xfer(input logic [7:0] d, input bit keep);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        if (!keep) in_valid = 1'b0;
    endtask

    task automatic watch(input logic [7:0] c, input logic [7:0] d, input int dv,
                         input bit chain, input logic [7:0] nxt,
                         input int mid_i, input logic [7:0] mid_c, input string tag);
        int total = frame_ticks(c) * dv;
        int bad_t = 0;
        int bad_r = 0;
        int a_t = 0;
        int e_t = 0;
        int a_r = 0;
        int e_r = 0;
        for (int i = 0; i < total; i++) begin
            logic e;
            logic er;
            if (i > 0) @(negedge clk);
            e  = exp_line(c, d, i / dv);
            er = (i == total - 1);
            if (txd !== e) begin
                if (bad_t == 0) begin a_t = {i, 1'b0} | int'(txd); e_t = {i, 1'b0} | int'(e); end
                bad_t++;
            end
            if (in_ready !== er) begin
                if (bad_r == 0) begin a_r = {i, 1'b0} | int'(in_ready); e_r = {i, 1'b0} | int'(er); end
                bad_r++;
            end
            if (chain && i == 0) in_data = nxt;
            if (i == mid_i) begin
                ctl_we = 1'b1;
                ctl_wdata = mid_c;
            end else if (mid_i >= 0 && i == mid_i + 1) begin
                ctl_we = 1'b0;
            end
        end
        // values printed as {cycle, level}
        check(bad_t == 0, tag, a_t, e_t);
        check(bad_r == 0, "R9 ready only on last stop enable", a_r, e_r);
        if (!chain) begin
            @(negedge clk);
            check(!busy && txd && in_ready, "R1 R2 back to idle",
                  int'({busy, txd, in_ready}), 3);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] vals [3];
        vals[0] = 8'hA5;
        vals[1] = 8'h3C;
        vals[2] = 8'hE9;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd && in_ready && !busy, "R1 reset outputs",
              int'({txd, in_ready, busy}), 6);

        // R1 R2 default format: 5 bits, no parity, one stop
        xfer(8'h2D, 1'b0);
        watch(8'h00, 8'h2D, 1, 1'b0, 8'h00, -1, 8'h00, "R1 R2 default frame");

        // R7 break
        wr_ctl(8'h40);
        check(txd == 1'b0, "R7 break low", int'(txd), 0);
        repeat (5) @(negedge clk);
        check(txd == 1'b0, "R7 break held", int'(txd), 0);
        wr_ctl(8'h00);
        check(txd == 1'b1, "R7 break released", int'(txd), 1);

        // R8 divisor loading and slower frame
        wr_ctl(8'h80);
        check(in_ready == 1'b1, "R8 ready in divisor mode", int'(in_ready), 1);
        xfer(8'd3, 1'b0);
        check(!busy && txd, "R8 divisor write starts no frame", int'({busy, txd}), 1);
        wr_ctl(8'h0B);
        xfer(8'hC6, 1'b0);
        watch(8'h0B, 8'hC6, 3, 1'b0, 8'h00, -1, 8'h00, "R8 divisor 3 frame");
        wr_ctl(8'h80);
        xfer(8'd0, 1'b0);
        wr_ctl(8'h1D);
        xfer(8'h5B, 1'b0);
        watch(8'h1D, 8'h5B, 1, 1'b0, 8'h00, -1, 8'h00, "R8 divisor zero acts as one");

        // R3 R4 R5 R6 sweep over every format code
        for (int f = 0; f < 64; f++) begin
            for (int v = 0; v < 3; v++) begin
                wr_ctl(8'(f));
                xfer(vals[v], 1'b0);
                watch(8'(f), vals[v], 1, 1'b0, 8'h00, -1, 8'h00, "R3 R4 R5 R6 format sweep");
            end
        end

        // R10 control write mid-frame
        wr_ctl(8'h03);
        xfer(8'h6B, 1'b0);
        watch(8'h03, 8'h6B, 1, 1'b0, 8'h00, 20, 8'h2C, "R10 frame unchanged by mid write");
        xfer(8'h6B, 1'b0);
        watch(8'h2C, 8'h6B, 1, 1'b0, 8'h00, -1, 8'h00, "R10 new format on next frame");

        // R9 back-to-back frames
        wr_ctl(8'h07);
        xfer(8'h81, 1'b1);
        watch(8'h07, 8'h81, 1, 1'b1, 8'h7E, -1, 8'h00, "R9 first chained frame");
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        watch(8'h07, 8'h7E, 1, 1'b0, 8'h00, -1, 8'h00, "R9 second frame with no gap");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule